// File: doc/BRIEF.md
# Four-Bin Streaming Fourier Correlator

This block is a coprocessor on a 32-bit word bus. It correlates a block of 24 real samples against cosine and sine waves at four bin frequencies. Bin k, for k = 1 to 4, completes k periods over the 24-sample block. All eight correlation sums are updated together for each sample. Software drives the block through two word offsets. A write to the input offset is either a command or a sample. After a start command, plain data writes are taken as the samples x[0] to x[23], and no command is needed between samples.

When the block is full, software writes a select command that picks the cosine set or the sine set. Successive reads of the output offset then return bin 1, bin 2, bin 3 and bin 4 in that order. When no set is selected, the output offset returns a progress word. The coefficients are signed Q1.14 values. Each sum is signed 32-bit and clamps at its limits instead of wrapping.

Top module: `dft_bin_accel`

## Requirements
- R1: After hardware reset, all sums and the sample count are zero, no set is selected, and a read of the output offset (word address 1) returns 0.
- R2: A write to the input offset (word address 0) with bit 31 set is a start command. In the next cycle, all eight sums and the sample count are zero and no set is selected.
- R3: A write to the input offset with bits 31:29 all zero is a data write. While fewer than 24 samples are held, it takes bits 15:0 as the next signed sample and raises the count by one.
- R4: With the cosine set selected (input-offset write with bit 31 clear and bit 30 set), the first four output reads return sum over n of x[n]*round(16384*cos(2*pi*k*n/24)) for k = 1, 2, 3, 4 in order.
- R5: With the sine set selected (input-offset write with bits 31 and 30 clear and bit 29 set), the first four output reads return the same sums formed with sin in place of cos, for k = 1 to 4 in order.
- R6: Once four values have been read from a selected set, further output reads return 0.
- R7: Every cosine-select or sine-select command restarts the output sequence at bin 1, even partway through a sequence.
- R8: Data writes made after 24 samples are held change no sum and leave the count unchanged, until the next start command.
- R9: Each sum is updated with a clamp at every sample. A result above 2147483647 gives 2147483647, and a result below -2147483648 gives -2147483648.
- R10: Command bits are taken in priority order: bit 31 (start) over bit 30 (cosine) over bit 29 (sine).
- R11: Writes to word addresses other than 0 have no effect, and reads at addresses other than 1 return 0.
- R12: With no set selected, an output read returns bit 31 = 1 exactly when 24 samples are held. Bits 4:0 hold the sample count and all other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Word address: 0 = command/sample input, 1 = result output |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; on the output offset it advances the result sequence |
| bus_rdata | output | 32 | Read data, combinational from address and state |

## Verification
A wrong phase step or a misread coefficient in one bin changes only that bin's entry in both sets. It shows up as soon as the sums are read after a full block, so the bench uses patterns whose energy falls in different bins. A sample counter that is off by one shows up at once in the progress word, and also shows up when extra writes change the sums. Read-pointer faults change the order of the values, or the zero tail, on the first sequence read after a select command.

// File: rtl/dft_acc_pkg.sv
package dft_acc_pkg;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_COS  = 2'd1,
      SEL_SIN  = 2'd2
   } rsel_e;

   localparam int CMD_START_BIT = 31;
   localparam int CMD_COS_BIT   = 30;
   localparam int CMD_SIN_BIT   = 29;

   // Q1.14 first-quadrant cosine magnitudes, 15 degree steps (0..90)
   function automatic int quarter_q14(input int j);
      case (j)
         0: return 16384;
         1: return 15826;
         2: return 14189;
         3: return 11585;
         4: return 8192;
         5: return 4240;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/dft_twiddle.sv
module dft_twiddle #(
   parameter int N_PTS  = 24,
   parameter int COEF_W = 16,
   parameter int IDX_W  = $clog2(N_PTS)
) (
   input  logic [IDX_W-1:0]         idx,
   output logic signed [COEF_W-1:0] cos_o,
   output logic signed [COEF_W-1:0] sin_o
);
   import dft_acc_pkg::*;

   localparam int QTR  = N_PTS / 4;
   localparam int HALF = N_PTS / 2;

   initial begin
      if (N_PTS != 24) $error("dft_twiddle: coefficient table covers N_PTS=24 only");
      if (COEF_W < 16) $error("dft_twiddle: COEF_W must hold Q1.14 values");
   end

   // cosine over a full period built from the quarter table
   function automatic int cos_full(input int m);
      if (m <= QTR)             return  quarter_q14(m);
      else if (m <= HALF)       return -quarter_q14(HALF - m);
      else if (m <= HALF + QTR) return -quarter_q14(m - HALF);
      else                      return  quarter_q14(N_PTS - m);
   endfunction

   always_comb begin
      int m;
      int ms;
      m = int'(idx);
      ms = (m + N_PTS - QTR) % N_PTS;  // sin(theta) = cos(theta - 90 deg)
      cos_o = COEF_W'(cos_full(m));
      sin_o = COEF_W'(cos_full(ms));
   end

endmodule

// File: rtl/dft_bin_mac.sv
module dft_bin_mac #(
   parameter int N_PTS  = 24,
   parameter int BIN_K  = 1,
   parameter int SAMP_W = 16,
   parameter int COEF_W = 16,
   parameter int ACC_W  = 32,
   parameter bit SAT_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear,
   input  logic                     step,
   input  logic signed [SAMP_W-1:0] sample,
   output logic signed [ACC_W-1:0]  acc_cos,
   output logic signed [ACC_W-1:0]  acc_sin
);
   localparam int IDX_W  = $clog2(N_PTS);
   localparam int PROD_W = SAMP_W + COEF_W;
   localparam int KSTEP  = BIN_K % N_PTS;

   initial begin
      if (ACC_W < PROD_W) $error("dft_bin_mac: ACC_W narrower than product");
      if (BIN_K < 1) $error("dft_bin_mac: BIN_K must be positive");
   end

   logic [IDX_W-1:0]         phase_q, phase_nxt;
   logic [IDX_W:0]           phase_sum;
   logic signed [COEF_W-1:0] tw_cos, tw_sin;
   logic signed [PROD_W-1:0] prod_c, prod_s;
   logic signed [ACC_W:0]    sum_c, sum_s;
   logic signed [ACC_W-1:0]  nxt_c, nxt_s;

   dft_twiddle #(.N_PTS(N_PTS), .COEF_W(COEF_W), .IDX_W(IDX_W)) u_tw (
      .idx   (phase_q),
      .cos_o (tw_cos),
      .sin_o (tw_sin)
   );

   // phase walks by k per sample, modulo N_PTS: equals (k*n) mod N_PTS
   assign phase_sum = {1'b0, phase_q} + (IDX_W+1)'(KSTEP);
   assign phase_nxt = (phase_sum >= (IDX_W+1)'(N_PTS))
                    ? IDX_W'(phase_sum - (IDX_W+1)'(N_PTS))
                    : IDX_W'(phase_sum);

   assign prod_c = PROD_W'(sample) * PROD_W'(tw_cos);
   assign prod_s = PROD_W'(sample) * PROD_W'(tw_sin);
   assign sum_c  = (ACC_W+1)'(acc_cos) + (ACC_W+1)'(prod_c);
   assign sum_s  = (ACC_W+1)'(acc_sin) + (ACC_W+1)'(prod_s);

   function automatic logic signed [ACC_W-1:0] clamp(input logic signed [ACC_W:0] s);
      if (s[ACC_W] != s[ACC_W-1])
         return s[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
      return s[ACC_W-1:0];
   endfunction

   generate
      if (SAT_EN) begin : g_sat
         assign nxt_c = clamp(sum_c);
         assign nxt_s = clamp(sum_s);
      end else begin : g_wrap
         assign nxt_c = sum_c[ACC_W-1:0];
         assign nxt_s = sum_s[ACC_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
         acc_cos <= '0;
         acc_sin <= '0;
      end else if (clear) begin
         phase_q <= '0;
         acc_cos <= '0;
         acc_sin <= '0;
      end else if (step) begin
         phase_q <= phase_nxt;
         acc_cos <= nxt_c;
         acc_sin <= nxt_s;
      end
   end

endmodule

// File: rtl/dft_bus_ctrl.sv
module dft_bus_ctrl #(
   parameter int N_PTS  = 24,
   parameter int N_BINS = 4,
   parameter int BUS_W  = 32,
   parameter int ADDR_W = 2,
   parameter int SAMP_W = 16,
   parameter int IN_OFS = 0,
   localparam int CNT_W = $clog2(N_PTS + 1),
   localparam int PTR_W = $clog2(N_BINS + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic                     bus_wr,
   input  logic [BUS_W-1:0]         bus_wdata,
   input  logic                     rd_out,
   output logic                     clear,
   output logic                     step,
   output logic signed [SAMP_W-1:0] sample,
   output dft_acc_pkg::rsel_e       sel,
   output logic [PTR_W-1:0]         ptr,
   output logic [CNT_W-1:0]         count
);
   import dft_acc_pkg::*;

   logic wr_in, cmd_start, cmd_cos, cmd_sin, data_wr;

   assign wr_in     = bus_wr && (bus_addr == ADDR_W'(IN_OFS));
   assign cmd_start = wr_in && bus_wdata[CMD_START_BIT];
   assign cmd_cos   = wr_in && !bus_wdata[CMD_START_BIT] && bus_wdata[CMD_COS_BIT];
   assign cmd_sin   = wr_in && !bus_wdata[CMD_START_BIT] && !bus_wdata[CMD_COS_BIT]
                      && bus_wdata[CMD_SIN_BIT];
   assign data_wr   = wr_in && !bus_wdata[CMD_START_BIT] && !bus_wdata[CMD_COS_BIT]
                      && !bus_wdata[CMD_SIN_BIT];

   assign clear  = cmd_start;
   assign step   = data_wr && (count < CNT_W'(N_PTS));
   assign sample = bus_wdata[SAMP_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         sel   <= SEL_NONE;
         ptr   <= '0;
      end else begin
         if (cmd_start)   count <= '0;
         else if (step)   count <= count + CNT_W'(1);

         if (cmd_start)    sel <= SEL_NONE;
         else if (cmd_cos) sel <= SEL_COS;
         else if (cmd_sin) sel <= SEL_SIN;

         if (cmd_start || cmd_cos || cmd_sin)
            ptr <= '0;
         else if (rd_out && (sel != SEL_NONE) && (ptr < PTR_W'(N_BINS)))
            ptr <= ptr + PTR_W'(1);
      end
   end

endmodule

// File: rtl/dft_bin_accel.sv
module dft_bin_accel #(
   parameter int N_PTS   = 24,
   parameter int N_BINS  = 4,
   parameter int SAMP_W  = 16,
   parameter int COEF_W  = 16,
   parameter int ACC_W   = 32,
   parameter int BUS_W   = 32,
   parameter int ADDR_W  = 2,
   parameter int IN_OFS  = 0,
   parameter int OUT_OFS = 1,
   parameter bit SAT_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [BUS_W-1:0]  bus_wdata,
   input  logic              bus_rd,
   output logic [BUS_W-1:0]  bus_rdata
);
   import dft_acc_pkg::*;

   localparam int CNT_W = $clog2(N_PTS + 1);
   localparam int PTR_W = $clog2(N_BINS + 1);
   localparam int BIN_W = $clog2(N_BINS);

   initial begin
      if (BUS_W != 32) $error("dft_bin_accel: command bits assume a 32-bit bus");
      if (ACC_W > BUS_W) $error("dft_bin_accel: ACC_W exceeds bus width");
      if (N_BINS < 2 || N_BINS >= N_PTS / 2) $error("dft_bin_accel: N_BINS out of range");
      if (SAMP_W + 3 > BUS_W) $error("dft_bin_accel: samples overlap command bits");
      if (IN_OFS == OUT_OFS) $error("dft_bin_accel: offsets must differ");
      if (CNT_W >= BUS_W - 1) $error("dft_bin_accel: count field too wide");
   end

   logic                     clear, step;
   logic signed [SAMP_W-1:0] sample;
   rsel_e                    sel;
   logic [PTR_W-1:0]         ptr;
   logic [CNT_W-1:0]         count;
   logic                     rd_out;
   logic [N_BINS-1:0][ACC_W-1:0] acc_cos, acc_sin;

   assign rd_out = bus_rd && (bus_addr == ADDR_W'(OUT_OFS));

   dft_bus_ctrl #(
      .N_PTS(N_PTS), .N_BINS(N_BINS), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
      .SAMP_W(SAMP_W), .IN_OFS(IN_OFS)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .rd_out    (rd_out),
      .clear     (clear),
      .step      (step),
      .sample    (sample),
      .sel       (sel),
      .ptr       (ptr),
      .count     (count)
   );

   generate
      for (genvar b = 0; b < N_BINS; b++) begin : g_bin
         logic signed [ACC_W-1:0] c_acc, s_acc;
         dft_bin_mac #(
            .N_PTS(N_PTS), .BIN_K(b + 1), .SAMP_W(SAMP_W), .COEF_W(COEF_W),
            .ACC_W(ACC_W), .SAT_EN(SAT_EN)
         ) u_mac (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (clear),
            .step    (step),
            .sample  (sample),
            .acc_cos (c_acc),
            .acc_sin (s_acc)
         );
         assign acc_cos[b] = c_acc;
         assign acc_sin[b] = s_acc;
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OUT_OFS)) begin
         unique case (sel)
            SEL_NONE: begin
               bus_rdata[BUS_W-1]   = (count == CNT_W'(N_PTS));
               bus_rdata[CNT_W-1:0] = count;
            end
            SEL_COS: if (ptr < PTR_W'(N_BINS))
               bus_rdata = BUS_W'($signed(acc_cos[ptr[BIN_W-1:0]]));
            SEL_SIN: if (ptr < PTR_W'(N_BINS))
               bus_rdata = BUS_W'($signed(acc_sin[ptr[BIN_W-1:0]]));
            default: bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/dft_bin_accel_chk.sv
module dft_bin_accel_chk #(
   parameter int N_PTS   = 24,
   parameter int N_BINS  = 4,
   parameter int ACC_W   = 32,
   parameter int BUS_W   = 32,
   parameter int ADDR_W  = 2,
   parameter int IN_OFS  = 0,
   parameter int OUT_OFS = 1,
   parameter int CNT_W   = 5,
   parameter int PTR_W   = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [ADDR_W-1:0]        bus_addr,
   input logic                     bus_wr,
   input logic [BUS_W-1:0]         bus_wdata,
   input logic [BUS_W-1:0]         bus_rdata,
   input logic [CNT_W-1:0]         count,
   input logic [PTR_W-1:0]         ptr,
   input logic [1:0]               sel,
   input logic [N_BINS-1:0][ACC_W-1:0] acc_cos,
   input logic [N_BINS-1:0][ACC_W-1:0] acc_sin
);
   logic wr_in, data_wr;
   assign wr_in   = bus_wr && (bus_addr == ADDR_W'(IN_OFS));
   assign data_wr = wr_in && (bus_wdata[31:29] == 3'b000);

   p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(N_PTS));

   p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && count < CNT_W'(N_PTS)) |=> count == $past(count) + CNT_W'(1));

   p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_in && bus_wdata[31]) |=> (count == '0 && acc_cos == '0 && acc_sin == '0
                                    && sel == 2'd0));

   p_ignore_extra_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && count == CNT_W'(N_PTS)) |=>
         ($stable(acc_cos) && $stable(acc_sin) && count == CNT_W'(N_PTS)));

   p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_in && !bus_wdata[31] && (bus_wdata[30] || bus_wdata[29])) |=> ptr == '0);

   p_tail_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OUT_OFS) && sel != 2'd0 && ptr == PTR_W'(N_BINS))
         |-> bus_rdata == '0);

   p_status_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OUT_OFS) && sel == 2'd0)
         |-> (bus_rdata[BUS_W-1] == (count == CNT_W'(N_PTS))));

   p_other_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr != ADDR_W'(OUT_OFS)) |-> bus_rdata == '0);

endmodule

bind dft_bin_accel dft_bin_accel_chk #(
   .N_PTS(N_PTS), .N_BINS(N_BINS), .ACC_W(ACC_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W),
   .IN_OFS(IN_OFS), .OUT_OFS(OUT_OFS), .CNT_W(CNT_W), .PTR_W(PTR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .count     (count),
   .ptr       (ptr),
   .sel       (sel),
   .acc_cos   (acc_cos),
   .acc_sin   (acc_sin)
);

// File: tb/tb_dft_bin_accel.sv
module tb_dft_bin_accel;

   localparam real PI = 3.14159265358979323846;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   longint mc[4];
   longint ms[4];
   int     xs[24];

   always #4 clk = ~clk;

   dft_bin_accel dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata)
   );

   function automatic int cq(input int m);
      return int'($floor(16384.0 * $cos(2.0 * PI * m / 24.0) + 0.5));
   endfunction
   function automatic int sq(input int m);
      return int'($floor(16384.0 * $sin(2.0 * PI * m / 24.0) + 0.5));
   endfunction
   function automatic longint clamp32(input longint v);
      if (v > 64'sd2147483647) return 64'sd2147483647;
      if (v < -64'sd2147483648) return -64'sd2147483648;
      return v;
   endfunction

   // reference sums from the requirements, clamped after every sample (R9)
   function automatic void run_model();
      for (int k = 0; k < 4; k++) begin
         mc[k] = 0;
         ms[k] = 0;
         for (int n = 0; n < 24; n++) begin
            mc[k] = clamp32(mc[k] + longint'(xs[n]) * cq(((k + 1) * n) % 24));
            ms[k] = clamp32(ms[k] + longint'(xs[n]) * sq(((k + 1) * n) % 24));
         end
      end
   endfunction

   task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   // driver: push expected value, then strobe one read
   task automatic bus_read(input logic [1:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      bus_addr = a;
      bus_rd   = 1'b1;
      @(negedge clk);
      bus_rd   = 1'b0;
   endtask

   task automatic load_block();
      bus_write(2'd0, 32'h8000_0000);
      for (int n = 0; n < 24; n++) bus_write(2'd0, {16'h0, xs[n][15:0]});
      run_model();
   endtask

   task automatic read_set(input bit use_sin, input string tag);
      bus_write(2'd0, use_sin ? 32'h2000_0000 : 32'h4000_0000);
      for (int k = 0; k < 4; k++)
         bus_read(2'd1, use_sin ? 32'(ms[k]) : 32'(mc[k]), tag);
   endtask

   // monitor: compare each observed output read with the queue head
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (bus_rd) begin
            logic [31:0] e;
            string       t;
            if (exp_q.size() == 0) begin
               n_tests++; n_fail++;
               $display("FAIL scoreboard: read with no expectation, actual %h expected none", bus_rdata);
            end else begin
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               n_tests++;
               if (bus_rdata !== e) begin
                  n_fail++;
                  $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
               end
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      bus_read(2'd1, 32'h0, "R1 reset status");

      // R3 / R12: ramp block, progress word part way and at full
      for (int n = 0; n < 24; n++) xs[n] = n * 731 - 9000;
      bus_write(2'd0, 32'h8000_0000);
      for (int n = 0; n < 10; n++) bus_write(2'd0, {16'h0, xs[n][15:0]});
      bus_read(2'd1, 32'd10, "R3 R12 count after ten");
      for (int n = 10; n < 24; n++) bus_write(2'd0, {16'h0, xs[n][15:0]});
      run_model();
      bus_read(2'd1, 32'h8000_0018, "R12 full status");

      // R4, R6: cosine set in order, then zero tail
      read_set(1'b0, "R4 cos ramp");
      bus_read(2'd1, 32'h0, "R6 tail zero");
      bus_read(2'd1, 32'h0, "R6 tail zero again");

      // R5: sine set
      read_set(1'b1, "R5 sin ramp");

      // R7: restart mid-sequence
      bus_write(2'd0, 32'h4000_0000);
      bus_read(2'd1, 32'(mc[0]), "R7 first");
      bus_read(2'd1, 32'(mc[1]), "R7 second");
      bus_write(2'd0, 32'h4000_0000);
      bus_read(2'd1, 32'(mc[0]), "R7 restart at bin 1");

      // R8: extra data writes ignored
      bus_write(2'd0, 32'h0000_7FFF);
      bus_write(2'd0, 32'h0000_1234);
      read_set(1'b0, "R8 cos after extra writes");
      read_set(1'b1, "R8 sin after extra writes");

      // R10 + R2: all command bits set acts as start
      bus_write(2'd0, 32'hE000_0000);
      bus_read(2'd1, 32'h0, "R10 R2 start wins, status clear");
      bus_write(2'd0, 32'h4000_0000);
      for (int k = 0; k < 4; k++) bus_read(2'd1, 32'h0, "R2 sums cleared");
      // R10: bit 30 beats bit 29 -> cosine set selected
      for (int n = 0; n < 24; n++) xs[n] = (n % 3 == 0) ? 500 : -250;
      load_block();
      bus_write(2'd0, 32'h6000_0000);
      for (int k = 0; k < 4; k++) bus_read(2'd1, 32'(mc[k]), "R10 cos over sin");

      // R11: other addresses
      bus_write(2'd0, 32'h8000_0000);
      bus_write(2'd2, 32'h0000_0100);
      bus_write(2'd3, 32'h0000_0100);
      bus_read(2'd1, 32'h0, "R11 writes elsewhere ignored");
      bus_read(2'd0, 32'h0, "R11 read at input offset");
      bus_read(2'd2, 32'h0, "R11 read at unused offset");

      // R4/R5: tone at bin 2
      for (int n = 0; n < 24; n++) xs[n] = int'($floor(1000.0 * $cos(2.0 * PI * 2 * n / 24.0) + 0.5));
      load_block();
      read_set(1'b0, "R4 cos tone");
      read_set(1'b1, "R5 sin tone");

      // R9: positive clamp on bin 1 cosine, negative on bin 1 sine
      for (int n = 0; n < 24; n++) xs[n] = (cq(n) >= 0) ? 32767 : -32767;
      load_block();
      read_set(1'b0, "R9 clamp cos");
      for (int n = 0; n < 24; n++) xs[n] = (sq(n) >= 0) ? -32767 : 32767;
      load_block();
      read_set(1'b1, "R9 clamp sin");
      if (mc[0] != 64'sd0 && ms[0] != -64'sd2147483648) begin
         n_tests++; n_fail++;
         $display("FAIL R9 model: actual %0d expected %0d", ms[0], -64'sd2147483648);
      end

      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_tests++; n_fail++;
         $display("FAIL scoreboard drain: actual %0d expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule